// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers thirteen level-sensitive request lines, numbered 1 to 13, and tells the processor which one to serve. Each line is captured every cycle into a pending register. A mask register can block any source. Among the sources that are pending and not masked, the controller picks the one with the largest combined level/priority key. It then drives a 3-bit interrupt level and an 8-bit vector number to the processor.

Every source has an 8-bit control byte with three fields: a 3-bit level, a 2-bit priority within that level, and an autovector select. The vector comes from one of two places. With autovector selected it is the fixed value 24 plus the level. Otherwise it is read from a programmable vector register that belongs to the source. Three sources own such a register: the watchdog source and the two serial-port sources. Every other source falls back to 0x0F. Software uses a small byte-addressed register port to program the control bytes, the mask and the vector registers, and to read back the pending lines.

Top module: `irqc_top`

## Requirements
- R1: The pending register follows the source lines. Bit i is loaded from line i on every clock. It reads at address 0x3A in data bits 13:1, with bits 0, 14 and 15 reading 0. A bus write to 0x3A changes nothing.
- R2: A source is active when it is pending and its mask bit is 0. The mask is written and read at address 0x36 in data bits 13:1. After reset the mask reads 0x3FFE, so every source is blocked.
- R3: The arbitration key is control bits 4:0: level in bits 4:2 and priority in bits 1:0. The active source with the strictly largest key wins. When keys are equal, the lowest-numbered source wins.
- R4: If no source is active, or the winning key is below 4 (level 0), the level output is 0 and the vector output is 0.
- R5: When an interrupt is presented, the level output equals the winner's control bits 4:2.
- R6: When control bit 7 of the winner is 1, the vector output is 24 + level.
- R7: When control bit 7 of the winner is 0, the vector comes from a register that depends on the winning source:

  | Winner | Vector register | Address | Reset value |
  |---|---|---|---|
  | Source 8 | Watchdog vector register | 0x42 | 0x0F |
  | Source 12 | Serial-port-A vector register | 0x44 | 0x00 |
  | Source 13 | Serial-port-B vector register | 0x46 | 0x00 |

  Any other winning source gives vector 0x0F.
- R8: Control bytes reset to these values:

  | Sources | Reset value |
  |---|---|
  | 1 to 7 | 4 × source number |
  | 8 | 0x1C |
  | 9, 10, 11 | 0x80 |
  | 12, 13 | 0x00 |
- R9: The control byte of source i is at address 0x13 + i. It is written from data bits 7:0 and reads back in bits 7:0. An unmapped address reads 0.
- R10: The level and vector outputs are registered. They change one clock after a change to the pending, mask or control registers. A source line change therefore reaches them on the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 13 | Source request lines; bit i is source i (1..13) |
| bus_addr_i | input | 8 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data for bus_addr_i |
| irq_level_o | output | 3 | Presented interrupt level, 0 when idle |
| irq_vector_o | output | 8 | Presented vector number, 0 when idle |

## Verification
The checks that look into the past compare pending and output registers with the source lines and the arbiter result of the previous cycle. They are held off until one full clock after reset has passed, so that they never see source values from before that point. No assumption is made about how source lines or bus writes line up with each other. The stimulus still changes inputs only on the falling edge, and it writes one register per pulse, so each write is a clean single-cycle event. The bench keeps shadow copies of every register it writes. From those copies it computes the expected level and vector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC   = 13;
    localparam int SRC_IDX_W = $clog2(NUM_SRC + 1);
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;

    localparam int CTRL_BASE = 'h13;
    localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h36;
    localparam logic [ADDR_W-1:0] PEND_ADDR = 8'h3A;
    localparam logic [ADDR_W-1:0] WDV_ADDR  = 8'h42;
    localparam logic [ADDR_W-1:0] UVA_ADDR  = 8'h44;
    localparam logic [ADDR_W-1:0] UVB_ADDR  = 8'h46;

    localparam int WDOG_SRC  = 8;
    localparam int UARTA_SRC = 12;
    localparam int UARTB_SRC = 13;
    localparam int AUTO_BASE = 24;
    localparam logic [7:0] DFLT_VEC = 8'h0F;

    typedef struct packed {
        logic       autovec;
        logic [1:0] spare;
        logic [2:0] level;
        logic [1:0] prio;
    } ctrl_t;

    typedef struct packed {
        logic                 hit;
        logic [SRC_IDX_W-1:0] src;
        ctrl_t                ctrl;
    } pick_t;

    function automatic logic [4:0] ctrl_key(input ctrl_t c);
        return {c.level, c.prio};
    endfunction

    function automatic ctrl_t ctrl_reset(input int idx);
        if (idx >= 1 && idx <= 7) return ctrl_t'(8'(idx * 4));
        if (idx == 8)             return ctrl_t'(8'h1C);
        if (idx >= 9 && idx <= 11) return ctrl_t'(8'h80);
        return ctrl_t'(8'h00);
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC:1]    src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N_SRC:1]    active_o,
    output ctrl_t             ctrl_o [1:N_SRC],
    output logic [7:0]        wdv_o,
    output logic [7:0]        uva_o,
    output logic [7:0]        uvb_o
);

    logic [N_SRC:1] pend_q;
    logic [N_SRC:1] mask_q;
    ctrl_t          ctrl_q [1:N_SRC];
    logic [7:0]     wdv_q, uva_q, uvb_q;
    logic           armed_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[DATA_W-1:N_SRC+1], wdata_i[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            mask_q  <= '1;
            wdv_q   <= DFLT_VEC;
            uva_q   <= '0;
            uvb_q   <= '0;
            armed_q <= 1'b0;
            for (int i = 1; i <= N_SRC; i++) ctrl_q[i] <= ctrl_reset(i);
        end else begin
            armed_q <= 1'b1;
            pend_q  <= src_i;
            if (wr_i) begin
                if (addr_i == MASK_ADDR) mask_q <= wdata_i[N_SRC:1];
                if (addr_i == WDV_ADDR)  wdv_q  <= wdata_i[7:0];
                if (addr_i == UVA_ADDR)  uva_q  <= wdata_i[7:0];
                if (addr_i == UVB_ADDR)  uvb_q  <= wdata_i[7:0];
                for (int i = 1; i <= N_SRC; i++) begin
                    if (addr_i == ADDR_W'(CTRL_BASE + i)) ctrl_q[i] <= ctrl_t'(wdata_i[7:0]);
                end
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == MASK_ADDR) rdata_o[N_SRC:1] = mask_q;
        if (addr_i == PEND_ADDR) rdata_o[N_SRC:1] = pend_q;
        if (addr_i == WDV_ADDR)  rdata_o[7:0] = wdv_q;
        if (addr_i == UVA_ADDR)  rdata_o[7:0] = uva_q;
        if (addr_i == UVB_ADDR)  rdata_o[7:0] = uvb_q;
        for (int i = 1; i <= N_SRC; i++) begin
            if (addr_i == ADDR_W'(CTRL_BASE + i)) rdata_o[7:0] = ctrl_q[i];
        end
    end

    assign active_o = pend_q & ~mask_q;
    assign wdv_o    = wdv_q;
    assign uva_o    = uva_q;
    assign uvb_o    = uvb_q;
    always_comb for (int i = 1; i <= N_SRC; i++) ctrl_o[i] = ctrl_q[i];

    // R1
    pend_track_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        pend_q == $past(src_i));

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(wr_i && addr_i == MASK_ADDR) |-> mask_q == $past(wdata_i[N_SRC:1]));

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic [N_SRC:1] active_i,
    input  ctrl_t          ctrl_i [1:N_SRC],
    output pick_t          pick_o
);

    logic [4:0]           best_key;
    logic [SRC_IDX_W-1:0] best_idx;
    ctrl_t                best_ctrl;

    always_comb begin
        best_key  = '0;
        best_idx  = '0;
        best_ctrl = '0;
        for (int i = 1; i <= N_SRC; i++) begin
            if (active_i[i] && ctrl_key(ctrl_i[i]) > best_key) begin
                best_key  = ctrl_key(ctrl_i[i]);
                best_idx  = SRC_IDX_W'(i);
                best_ctrl = ctrl_i[i];
            end
        end
        pick_o.hit  = (best_key[4:2] != 3'd0);
        pick_o.src  = best_idx;
        pick_o.ctrl = best_ctrl;
    end

endmodule

// File: rtl/irqc_vector.sv
module irqc_vector
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pick_t      pick_i,
    input  logic [7:0] wdv_i,
    input  logic [7:0] uva_i,
    input  logic [7:0] uvb_i,
    output logic [2:0] level_o,
    output logic [7:0] vector_o
);

    logic [2:0] level_d;
    logic [7:0] vector_d;
    logic       armed_q;

    always_comb begin
        level_d  = '0;
        vector_d = '0;
        if (pick_i.hit) begin
            level_d = pick_i.ctrl.level;
            if (pick_i.ctrl.autovec)                       vector_d = 8'(AUTO_BASE) + {5'b0, pick_i.ctrl.level};
            else if (pick_i.src == SRC_IDX_W'(WDOG_SRC))  vector_d = wdv_i;
            else if (pick_i.src == SRC_IDX_W'(UARTA_SRC)) vector_d = uva_i;
            else if (pick_i.src == SRC_IDX_W'(UARTB_SRC)) vector_d = uvb_i;
            else                                           vector_d = DFLT_VEC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_o  <= '0;
            vector_o <= '0;
            armed_q  <= 1'b0;
        end else begin
            level_o  <= level_d;
            vector_o <= vector_d;
            armed_q  <= 1'b1;
        end
    end

    // R4
    idle_out_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(!pick_i.hit) |-> (level_o == 3'd0 && vector_o == 8'd0));

    // R5
    level_out_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(pick_i.hit) |-> (level_o == $past(pick_i.ctrl.level) && level_o != 3'd0));

    // R6
    autovec_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $past(pick_i.hit && pick_i.ctrl.autovec) |-> vector_o == 8'(AUTO_BASE) + {5'b0, level_o});

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC:1]    irq_src_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [2:0]        irq_level_o,
    output logic [7:0]        irq_vector_o
);

    logic [N_SRC:1] active;
    ctrl_t          ctrl [1:N_SRC];
    logic [7:0]     wdv, uva, uvb;
    pick_t          pick;

    irqc_regs #(.N_SRC(N_SRC)) regs_i (
        .clk(clk), .rst(rst), .src_i(irq_src_i),
        .addr_i(bus_addr_i), .wr_i(bus_wr_i), .wdata_i(bus_wdata_i),
        .rdata_o(bus_rdata_o), .active_o(active), .ctrl_o(ctrl),
        .wdv_o(wdv), .uva_o(uva), .uvb_o(uvb)
    );

    irqc_arbiter #(.N_SRC(N_SRC)) arb_i (
        .active_i(active), .ctrl_i(ctrl), .pick_o(pick)
    );

    irqc_vector vec_i (
        .clk(clk), .rst(rst), .pick_i(pick),
        .wdv_i(wdv), .uva_i(uva), .uvb_i(uvb),
        .level_o(irq_level_o), .vector_o(irq_vector_o)
    );

    // R3
    winner_active_chk: assert property (@(posedge clk) disable iff (rst)
        pick.hit |-> active[pick.src]);

endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:1] irq_src = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_ctrl [1:13];
    logic [13:1] m_mask;
    int m_wdv, m_uva, m_uvb;

    always #2 clk = ~clk;

    irqc_top dut_i (
        .clk(clk), .rst(rst), .irq_src_i(irq_src),
        .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_level_o(irq_level), .irq_vector_o(irq_vector)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        bus_addr  = 8'(addr);
        bus_wdata = 16'(data);
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        if (addr == 'h36) m_mask = 13'(data >> 1);
        if (addr == 'h42) m_wdv = data & 'hFF;
        if (addr == 'h44) m_uva = data & 'hFF;
        if (addr == 'h46) m_uvb = data & 'hFF;
        if (addr >= 'h14 && addr <= 'h20) m_ctrl[addr - 'h13] = data & 'hFF;
    endtask

    task automatic rd(input int addr, output int data);
        bus_addr = 8'(addr);
        #0.5;
        data = int'(bus_rdata);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic void model(input logic [13:1] s, output int lv, output int vec);
        int bk = 0;
        int bi = 0;
        for (int i = 1; i <= 13; i++) begin
            if (s[i] && !m_mask[i] && (m_ctrl[i] & 31) > bk) begin
                bk = m_ctrl[i] & 31;
                bi = i;
            end
        end
        lv = bk >> 2;
        if (lv == 0) vec = 0;
        else if (m_ctrl[bi] & 'h80) vec = 24 + lv;
        else if (bi == 8) vec = m_wdv;
        else if (bi == 12) vec = m_uva;
        else if (bi == 13) vec = m_uvb;
        else vec = 'h0F;
    endfunction

    task automatic drive_and_check(input logic [13:1] s, input string req);
        int lv, vec;
        irq_src = s;
        settle();
        model(s, lv, vec);
        chk({req, " level"}, int'(irq_level), lv);
        chk({req, " vector"}, int'(irq_vector), vec);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int d;
        for (int i = 1; i <= 13; i++) m_ctrl[i] = (i <= 7) ? 4 * i : (i == 8) ? 'h1C : (i <= 11) ? 'h80 : 0;
        m_mask = '1; m_wdv = 'h0F; m_uva = 0; m_uvb = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8, R9: reset values of every control byte
        for (int i = 1; i <= 13; i++) begin
            rd('h13 + i, d);
            chk("R8 ctrl reset", d, m_ctrl[i]);
        end
        rd('h36, d); chk("R2 mask reset", d, 'h3FFE);
        rd('h42, d); chk("R7 watchdog vector reset", d, 'h0F);
        rd('h44, d); chk("R7 port A vector reset", d, 0);
        rd('h46, d); chk("R7 port B vector reset", d, 0);
        rd('h3A, d); chk("R1 pending reset", d, 0);
        rd('h50, d); chk("R9 unmapped read", d, 0);
        chk("R4 idle level after reset", int'(irq_level), 0);
        chk("R4 idle vector after reset", int'(irq_vector), 0);

        // R2: all sources masked after reset -> nothing presented
        drive_and_check(13'h1FFF, "R2 masked all");
        rd('h3A, d); chk("R1 pending follows lines", d, 'h3FFE);

        // R10: mask change reaches outputs one clock later
        irq_src = '0;
        irq_src[7] = 1'b1;
        settle();
        wr('h36, 0);
        chk("R10 level before update", int'(irq_level), 0);
        @(posedge clk); @(negedge clk);
        chk("R10 level after update", int'(irq_level), 7);
        chk("R10 vector after update", int'(irq_vector), 'h0F);

        // R1: write to pending is ignored
        irq_src = '0;
        settle();
        wr('h3A, 'hFFFF);
        rd('h3A, d); chk("R1 pending write ignored", d, 0);
        settle();
        chk("R1 no interrupt from pending write", int'(irq_level), 0);

        // R5, R7, R4: each source alone with reset control values
        for (int i = 1; i <= 13; i++) begin
            logic [13:1] s;
            s = '0; s[i] = 1'b1;
            drive_and_check(s, "R5 R7 single source default");
        end

        // R7: per-source vector registers
        wr('h42, 'h40); wr('h44, 'h50); wr('h46, 'h60);
        rd('h42, d); chk("R7 watchdog vector rw", d, 'h40);
        wr('h1B, 'h11); wr('h1F, 'h11); wr('h20, 'h12);
        rd('h1B, d); chk("R9 ctrl rw", d, 'h11);
        drive_and_check(13'h0080, "R7 watchdog vector");
        drive_and_check(13'h0800, "R7 port A vector");
        drive_and_check(13'h1000, "R7 port B vector");
        // R3: tie between 8 and 12 -> 8; 13 has larger key
        drive_and_check(13'h0880, "R3 tie lowest wins");
        drive_and_check(13'h1880, "R3 strictly larger key");

        // R4: level 0 with nonzero priority presents nothing
        wr('h14, 'h03);
        drive_and_check(13'h0001, "R4 level zero prio three");

        // R6: autovector
        wr('h15, 'h80 | 'h15);
        drive_and_check(13'h0002, "R6 autovector");

        // R3, R6, R7: sweep of control, mask and source patterns
        for (int i = 1; i <= 13; i++) wr('h13 + i, (i * 53 + 7) & 'h9F);
        for (int k = 0; k < 96; k++) begin
            logic [13:1] s;
            wr('h36, ((k * 'h2A7) ^ (k << 5)) & 'h3FFE & ((k % 4 == 0) ? 0 : 'hFFFF));
            s = 13'((k * 613) ^ (k * 29 >> 1) ^ 'h0A5);
            drive_and_check(s, "R3 sweep");
        end

        // R3: all keys equal -> lowest active wins
        for (int i = 1; i <= 13; i++) wr('h13 + i, 'h0E);
        wr('h36, 0);
        wr('h1B, 'h0E);
        drive_and_check(13'h1880, "R3 equal keys pick 8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule